// File: doc/BRIEF.md
# Slotted Audio Receive FIFO Controller

This block is the receive side of a time-division-multiplexed audio port. It sits behind the serial shifter, which hands over one completed 16-bit word at a time together with the number (0 to 3) of the frame slot the word came from. The controller keeps a word only when its slot is enabled and lies inside the configured number of slots per frame. A kept word goes either into a shared 16-entry receive FIFO or, when its slot is routed to DMA, into a holding register owned by that slot.

Software sees a single 16-bit control/status word. It holds the slot enable mask, the DMA routing mask, the FIFO warning limit, a sticky overflow flag and three live FIFO flags. The FIFO is drained through a show-ahead read port. Each DMA holding register raises its own request line while it holds data and DMA is enabled for that slot. A level interrupt follows FIFO occupancy.

Top module: `audio_rx_slotter`

## Requirements
- R1: After reset the control/status word reads 0x0004 (only the empty flag set), `dma_req` is 0 and `rx_irq` is 0.
- R2: Bit 1 (full) is 1 exactly when the FIFO holds 16 words, that is when the pointers are equal and the last pointer-moving access was a write.
- R3: Bit 2 (empty) is 1 exactly when the FIFO holds no words. A read strobe while empty has no effect on the FIFO.
- R4: Bit 0 (almost-full) is 1 when the number of stored words equals the warning limit in bits 15:12 and the FIFO is not empty. A limit of 0 therefore never sets it.
- R5: A word routed to the FIFO while bit 1 is set is discarded: the occupancy does not change, no interrupt or DMA request results, and bit 3 (overflow) becomes 1. Bit 3 stays set until software writes 1 to bit 3. When a new overflow and that clear fall in the same cycle, the flag stays set.
- R6: Bits 7:4 are the slot enable mask, where bit 4+n enables slot n. A word tagged with slot n is kept only when that bit is set and n is below `slot_cnt`. Other words are dropped without setting the overflow flag. The mask is 0 after reset.
- R7: Bits 11:8 are the DMA routing mask, where bit 8+n applies to slot n. A kept word of slot n whose DMA bit is set is written into holding register n (`dma_data[16n+15:16n]`) and leaves the FIFO unchanged.
- R8: `dma_req[n]` is 1 while holding register n holds unread data and `dma_en[n]` is 1. A pulse on `dma_rd[n]` empties the register from the next cycle on, unless a new word for slot n lands in the same cycle.
- R9: A DMA mask bit has no effect for a slot whose enable bit is clear: such a word reaches neither the FIFO nor a holding register.
- R10: `rx_irq` is 1 exactly when `irq_en` is 1 and the FIFO is not empty.
- R11: Words leave the FIFO in arrival order. `fifo_rd_data` shows the oldest stored word whenever the FIFO is not empty, and a `fifo_rd` pulse removes it.
- R12: Bits 2:0 are read-only. CPU writes do not change the full, empty or almost-full flags except through the warning limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld | input | 1 | One-cycle strobe: a completed word is offered |
| word_data | input | 16 | Completed received word |
| word_slot | input | 2 | Slot number the word belongs to |
| slot_cnt | input | 3 | Slots per frame (0 to 4); slots at or above it are ignored |
| csr_wr_en | input | 1 | Write strobe for the control/status word |
| csr_wr_data | input | 16 | Write data for the control/status word |
| csr_rd_data | output | 16 | Current control/status word |
| fifo_rd | input | 1 | Remove the oldest FIFO word |
| fifo_rd_data | output | 16 | Oldest FIFO word (show-ahead) |
| dma_en | input | 4 | Per-slot DMA request enable |
| dma_rd | input | 4 | Per-slot holding-register read strobe |
| dma_data | output | 64 | Holding registers, slot n in bits 16n+15:16n |
| dma_req | output | 4 | Per-slot DMA request |
| irq_en | input | 1 | Receive interrupt enable |
| rx_irq | output | 1 | Receive interrupt, level |

## Verification
The bench pushes the FIFO past sixteen entries, where a design that judged full from the pointers alone would call the full FIFO empty and lose all sixteen words. It also checks that the overflowing word leaves occupancy and interrupt untouched. It fires an overflow in the same cycle as the write that clears the flag, which a clear-wins design would lose. It sends words for slots that are disabled, that lie beyond the slot count, or that are DMA-routed but disabled, where a mis-decoded mask would leak them into the FIFO or a holding register. It also pops an empty FIFO and moves the warning limit across the occupancy, which catches a wrapped pointer or a limit of 0 that wrongly raises almost-full.

// File: rtl/aurx_pkg.sv
package aurx_pkg;
   // Control/status word field positions.
   localparam int unsigned CSR_W      = 16;
   localparam int unsigned B_AFULL    = 0;
   localparam int unsigned B_FULL     = 1;
   localparam int unsigned B_EMPTY    = 2;
   localparam int unsigned B_OVF      = 3;
   localparam int unsigned F_EN_LO    = 4;
   localparam int unsigned F_DMA_LO   = 8;
   localparam int unsigned F_LIM_LO   = 12;
   localparam int unsigned FIELD_W    = 4;
   localparam logic [CSR_W-1:0] CSR_RST = 16'h0004;

   typedef enum logic [1:0] {
      RT_DROP = 2'd0,
      RT_FIFO = 2'd1,
      RT_DMA  = 2'd2
   } route_e;

   typedef struct packed {
      logic [FIELD_W-1:0] limit;
      logic [FIELD_W-1:0] dma_mask;
      logic [FIELD_W-1:0] en_mask;
      logic               ovf;
   } ctl_t;
endpackage

// File: rtl/aurx_fifo.sv
module aurx_fifo #(
   parameter int unsigned DW = 16,
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          full,
   output logic          empty,
   output logic          ovf_evt,
   output logic [AW:0]   count
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          last_wr;
   logic          do_push, do_pop, same;

   assign same    = (wp == rp);
   assign full    = same &&  last_wr;
   assign empty   = same && !last_wr;
   assign do_push = push && !full;
   assign do_pop  = pop  && !empty;
   assign ovf_evt = push &&  full;
   assign rdata   = mem[rp];
   assign count   = full ? (AW+1)'(DEPTH) : {1'b0, wp - rp};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp      <= '0;
         rp      <= '0;
         last_wr <= 1'b0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         if (do_push && !do_pop)      last_wr <= 1'b1;
         else if (do_pop && !do_push) last_wr <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end
endmodule

// File: rtl/aurx_slot_route.sv
module aurx_slot_route #(
   parameter int unsigned NSLOT = 4,
   localparam int unsigned SLW  = $clog2(NSLOT)
) (
   input  logic             vld,
   input  logic [SLW-1:0]   slot,
   input  logic [SLW:0]     slot_cnt,
   input  logic [NSLOT-1:0] en_mask,
   input  logic [NSLOT-1:0] dma_mask,
   output logic             fifo_push,
   output logic [NSLOT-1:0] dma_wr
);
   import aurx_pkg::*;

   route_e sel [NSLOT];
   logic [NSLOT-1:0] to_fifo;

   for (genvar n = 0; n < NSLOT; n++) begin : g_slot
      logic hit;
      assign hit = vld && (slot == SLW'(n)) && ((SLW+1)'(n) < slot_cnt);
      always_comb begin
         if (!hit || !en_mask[n]) sel[n] = RT_DROP;
         else if (dma_mask[n])    sel[n] = RT_DMA;
         else                     sel[n] = RT_FIFO;
      end
      assign dma_wr[n]  = (sel[n] == RT_DMA);
      assign to_fifo[n] = (sel[n] == RT_FIFO);
   end

   assign fifo_push = |to_fifo;
endmodule

// File: rtl/aurx_dma_regs.sv
module aurx_dma_regs #(
   parameter int unsigned DW    = 16,
   parameter int unsigned NSLOT = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NSLOT-1:0]    wr,
   input  logic [DW-1:0]       wdata,
   input  logic [NSLOT-1:0]    rd,
   input  logic [NSLOT-1:0]    req_en,
   output logic [NSLOT*DW-1:0] data,
   output logic [NSLOT-1:0]    req
);
   for (genvar n = 0; n < NSLOT; n++) begin : g_reg
      logic [DW-1:0] hold;
      logic          loaded;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold   <= '0;
            loaded <= 1'b0;
         end else if (wr[n]) begin
            hold   <= wdata;
            loaded <= 1'b1;
         end else if (rd[n]) begin
            loaded <= 1'b0;
         end
      end
      assign data[n*DW +: DW] = hold;
      assign req[n]           = loaded && req_en[n];
   end
endmodule

// File: rtl/audio_rx_slotter.sv
module audio_rx_slotter #(
   parameter int unsigned DW    = 16,
   parameter int unsigned AW    = 4,
   parameter int unsigned NSLOT = 4,
   localparam int unsigned SLW  = $clog2(NSLOT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                word_vld,
   input  logic [DW-1:0]       word_data,
   input  logic [SLW-1:0]      word_slot,
   input  logic [SLW:0]        slot_cnt,
   input  logic                csr_wr_en,
   input  logic [15:0]         csr_wr_data,
   output logic [15:0]         csr_rd_data,
   input  logic                fifo_rd,
   output logic [DW-1:0]       fifo_rd_data,
   input  logic [NSLOT-1:0]    dma_en,
   input  logic [NSLOT-1:0]    dma_rd,
   output logic [NSLOT*DW-1:0] dma_data,
   output logic [NSLOT-1:0]    dma_req,
   input  logic                irq_en,
   output logic                rx_irq
);
   import aurx_pkg::*;

   initial begin
      if (NSLOT != FIELD_W) $error("NSLOT must match the 4-bit mask fields");
      if (AW < 4 || AW > 8) $error("AW must lie in 4..8");
      if (DW < 1)           $error("DW must be positive");
   end

   ctl_t          ctl;
   logic          push, full, empty, ovf_evt, afull;
   logic [AW:0]   count;
   logic [NSLOT-1:0] dma_wr;

   aurx_slot_route #(.NSLOT(NSLOT)) u_route (
      .vld       (word_vld),
      .slot      (word_slot),
      .slot_cnt  (slot_cnt),
      .en_mask   (ctl.en_mask),
      .dma_mask  (ctl.dma_mask),
      .fifo_push (push),
      .dma_wr    (dma_wr)
   );

   aurx_fifo #(.DW(DW), .AW(AW)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .wdata   (word_data),
      .pop     (fifo_rd),
      .rdata   (fifo_rd_data),
      .full    (full),
      .empty   (empty),
      .ovf_evt (ovf_evt),
      .count   (count)
   );

   aurx_dma_regs #(.DW(DW), .NSLOT(NSLOT)) u_dma (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (dma_wr),
      .wdata  (word_data),
      .rd     (dma_rd),
      .req_en (dma_en),
      .data   (dma_data),
      .req    (dma_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else begin
         if (csr_wr_en) begin
            ctl.limit    <= csr_wr_data[F_LIM_LO +: FIELD_W];
            ctl.dma_mask <= csr_wr_data[F_DMA_LO +: FIELD_W];
            ctl.en_mask  <= csr_wr_data[F_EN_LO  +: FIELD_W];
         end
         if (ovf_evt)
            ctl.ovf <= 1'b1;
         else if (csr_wr_en && csr_wr_data[B_OVF])
            ctl.ovf <= 1'b0;
      end
   end

   assign afull       = !empty && (count == {{(AW-3){1'b0}}, ctl.limit});
   assign csr_rd_data = {ctl.limit, ctl.dma_mask, ctl.en_mask, ctl.ovf, empty, full, afull};
   assign rx_irq      = irq_en && !empty;
endmodule

// File: rtl/aurx_chk.sv
module aurx_chk #(
   parameter int unsigned DW    = 16,
   parameter int unsigned AW    = 4,
   parameter int unsigned NSLOT = 4,
   localparam int unsigned SLW  = $clog2(NSLOT)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                word_vld,
   input logic                csr_wr_en,
   input logic [15:0]         csr_wr_data,
   input logic [15:0]         csr_rd_data,
   input logic                fifo_rd,
   input logic [NSLOT-1:0]    dma_en,
   input logic [NSLOT-1:0]    dma_rd,
   input logic [NSLOT-1:0]    dma_req,
   input logic                irq_en,
   input logic                rx_irq
);
   // R2
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd_data[1] && !fifo_rd) |=> csr_rd_data[1]);
   // R3
   full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(csr_rd_data[1] && csr_rd_data[2]));
   // R4
   afull_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rd_data[0] |-> !csr_rd_data[2]);
   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd_data[3] && !(csr_wr_en && csr_wr_data[3])) |=> csr_rd_data[3]);
   // R8
   dma_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req & ~dma_en) == '0);
   // R8
   dma_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&dma_rd && !word_vld) |=> (dma_req == '0));
   // R10
   irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> !csr_rd_data[2]);
   // R12
   ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr_en && !word_vld && !fifo_rd) |=> $stable(csr_rd_data[2:1]));
endmodule

bind audio_rx_slotter aurx_chk #(.DW(DW), .AW(AW), .NSLOT(NSLOT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .word_vld    (word_vld),
   .csr_wr_en   (csr_wr_en),
   .csr_wr_data (csr_wr_data),
   .csr_rd_data (csr_rd_data),
   .fifo_rd     (fifo_rd),
   .dma_en      (dma_en),
   .dma_rd      (dma_rd),
   .dma_req     (dma_req),
   .irq_en      (irq_en),
   .rx_irq      (rx_irq)
);

// File: tb/audio_rx_slotter_bench.sv
`timescale 1ns/1ps
module audio_rx_slotter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        word_vld = 1'b0;
   logic [15:0] word_data = '0;
   logic [1:0]  word_slot = '0;
   logic [2:0]  slot_cnt = 3'd4;
   logic        csr_wr_en = 1'b0;
   logic [15:0] csr_wr_data = '0;
   logic [15:0] csr_rd_data;
   logic        fifo_rd = 1'b0;
   logic [15:0] fifo_rd_data;
   logic [3:0]  dma_en = '0;
   logic [3:0]  dma_rd = '0;
   logic [63:0] dma_data;
   logic [3:0]  dma_req;
   logic        irq_en = 1'b0;
   logic        rx_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   audio_rx_slotter u_audio_rx_slotter (.*);

   // Behavioural reference
   logic [15:0] q[$];
   logic [3:0]  m_en, m_dm, m_lim;
   bit          m_ovf;
   logic [15:0] m_dd [4];
   logic [3:0]  m_df;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_en = '0; m_dm = '0; m_lim = '0; m_ovf = 0; m_df = '0;
         for (int i = 0; i < 4; i++) m_dd[i] = '0;
      end else begin
         bit keep, to_dma, to_fifo, was_full, was_empty, set_ovf;
         keep     = word_vld && (32'(word_slot) < 32'(slot_cnt)) && m_en[word_slot];
         to_dma   = keep && m_dm[word_slot];
         to_fifo  = keep && !m_dm[word_slot];
         was_full = (q.size() == 16);
         was_empty = (q.size() == 0);
         set_ovf  = to_fifo && was_full;
         if (fifo_rd && !was_empty) void'(q.pop_front());
         if (to_fifo && !was_full) q.push_back(word_data);
         for (int i = 0; i < 4; i++) if (dma_rd[i]) m_df[i] = 1'b0;
         if (to_dma) begin
            m_dd[word_slot] = word_data;
            m_df[word_slot] = 1'b1;
         end
         if (csr_wr_en) begin
            m_lim = csr_wr_data[15:12];
            m_dm  = csr_wr_data[11:8];
            m_en  = csr_wr_data[7:4];
            if (csr_wr_data[3]) m_ovf = 0;
         end
         if (set_ovf) m_ovf = 1;
      end
   end

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare every cycle at the falling edge, before inputs move
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int sz;
         sz = q.size();
         chk("R4 afull",   64'(csr_rd_data[0]), 64'(sz == int'(m_lim) && sz != 0));
         chk("R2 full",    64'(csr_rd_data[1]), 64'(sz == 16));
         chk("R3 empty",   64'(csr_rd_data[2]), 64'(sz == 0));
         chk("R5 ovf",     64'(csr_rd_data[3]), 64'(m_ovf));
         chk("R6 fields",  64'(csr_rd_data[15:4]), 64'({m_lim, m_dm, m_en}));
         if (sz != 0) chk("R11 fifo data", 64'(fifo_rd_data), 64'(q[0]));
         chk("R8 dma_req", 64'(dma_req), 64'(m_df & dma_en));
         for (int i = 0; i < 4; i++)
            if (m_df[i]) chk("R7 dma data", 64'(dma_data[i*16 +: 16]), 64'(m_dd[i]));
         chk("R10 irq",    64'(rx_irq), 64'(irq_en && sz != 0));
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask
   task automatic push(input logic [1:0] s, input logic [15:0] d);
      word_vld = 1'b1; word_slot = s; word_data = d; tick(); word_vld = 1'b0;
   endtask
   task automatic pop();
      fifo_rd = 1'b1; tick(); fifo_rd = 1'b0;
   endtask
   task automatic wcsr(input logic [15:0] v);
      csr_wr_en = 1'b1; csr_wr_data = v; tick(); csr_wr_en = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 csr reset", 64'(csr_rd_data), 64'h0004);
      chk("R1 dma_req reset", 64'(dma_req), 64'h0);
      chk("R1 irq reset", 64'(rx_irq), 64'h0);

      // R6: slots 0,1 enabled, limit 5; slots 2,3 dropped
      irq_en = 1'b1;
      wcsr(16'h5030);
      push(2'd2, 16'hAAAA);
      push(2'd3, 16'hBBBB);
      chk("R6 disabled slot dropped", 64'(csr_rd_data[2]), 64'h1);
      // R2 fill past full, R5 overflow
      for (int i = 0; i < 18; i++) push(2'(i % 2), 16'(16'h1000 + i));
      chk("R2 full after 16", 64'(csr_rd_data[1]), 64'h1);
      chk("R5 overflow set", 64'(csr_rd_data[3]), 64'h1);
      chk("R5 dropped word absent", 64'(fifo_rd_data), 64'h1000);
      // R5 overflow with same-cycle clear: set wins
      csr_wr_en = 1'b1; csr_wr_data = 16'h5038;
      word_vld = 1'b1; word_slot = 2'd0; word_data = 16'hDEAD;
      tick();
      csr_wr_en = 1'b0; word_vld = 1'b0;
      chk("R5 set beats clear", 64'(csr_rd_data[3]), 64'h1);
      wcsr(16'h5038);
      chk("R5 cleared by write 1", 64'(csr_rd_data[3]), 64'h0);
      // R12 read-only low bits
      wcsr(16'h5030 | 16'h0004);
      chk("R12 low bits unchanged", 64'(csr_rd_data[2:1]), 64'h1);
      // R3/R11 drain and extra pops
      for (int i = 0; i < 18; i++) pop();
      chk("R3 empty after drain", 64'(csr_rd_data[2]), 64'h1);
      chk("R10 irq low when empty", 64'(rx_irq), 64'h0);

      // R7/R8 DMA routing on slot 2
      dma_en = 4'hF;
      wcsr(16'h0470);
      push(2'd2, 16'h2222);
      chk("R7 fifo untouched by dma", 64'(csr_rd_data[2]), 64'h1);
      chk("R8 req raised", 64'(dma_req), 64'h4);
      dma_rd = 4'h4; tick(); dma_rd = '0;
      chk("R8 req cleared", 64'(dma_req), 64'h0);
      // R9 DMA bit on disabled slot 3
      wcsr(16'h0870);
      push(2'd3, 16'h3333);
      chk("R9 no dma req", 64'(dma_req), 64'h0);
      chk("R9 no fifo entry", 64'(csr_rd_data[2]), 64'h1);
      // R6 slot beyond slot count
      wcsr(16'h00F0);
      slot_cnt = 3'd2;
      push(2'd2, 16'h4444);
      chk("R6 slot beyond count", 64'(csr_rd_data[2]), 64'h1);
      push(2'd1, 16'h5555);
      chk("R11 in-range word kept", 64'(fifo_rd_data), 64'h5555);
      slot_cnt = 3'd4;

      // Random phases: fill-heavy then drain-heavy
      for (int ph = 0; ph < 6; ph++) begin
         for (int c = 0; c < 1500; c++) begin
            word_vld  = 1'($urandom % 2);
            word_slot = 2'($urandom);
            word_data = 16'($urandom);
            fifo_rd   = (ph % 2 == 0) ? ($urandom % 5 == 0) : ($urandom % 5 != 0);
            dma_rd    = 4'($urandom) & 4'($urandom);
            if ($urandom % 50 == 0) dma_en = 4'($urandom);
            if ($urandom % 30 == 0) irq_en = 1'($urandom);
            if ($urandom % 200 == 0) slot_cnt = 3'($urandom % 5);
            csr_wr_en   = ($urandom % 40 == 0);
            csr_wr_data = 16'($urandom);
            tick();
         end
      end
      word_vld = 1'b0; fifo_rd = 1'b0; csr_wr_en = 1'b0; dma_rd = '0;
      tick();
      finish_run();
   end
endmodule